// File: doc/BRIEF.md
# Power Button Conditioner

This block cleans up an active-low push button for a power management controller. It brings the raw pin into the clock domain through a short flop chain. It then filters out bounce on both the press and the release. A transition is accepted only once the new level has persisted for a programmable number of time-base ticks. A control input can turn the filter off, so that the synchronised pin drives the output directly.

The filtered level is the block's main output. Alongside it come a one-clock pulse on every accepted press and a one-clock override pulse. The override pulse fires when a single continuous press outlasts a long hold threshold. Both thresholds are counted in pulses of a slow tick input, typically one per millisecond. The defaults give a debounce window of 16 ticks, which is just above 15.8 ms. The hold threshold defaults to 4001 ticks, which is just above 4 s. A bench can set both much smaller.

Top module: `btn_conditioner`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `key_clean_n` is 1 (released) and `press_pulse` and `override_pulse` are 0, whatever the pin does.
- R2: With `dbnc_bypass` = 1, a change on `key_raw_n` appears on `key_clean_n` on the third rising edge after it is applied. Two edges go to the synchroniser and one to the output register.
- R3: With `dbnc_bypass` = 0, a new synchronised level is taken onto `key_clean_n` only on the DBNC_TICKS-th `ms_tick` during which it has differed from `key_clean_n`. A pulse on the pin seen for fewer ticks never changes the output.
- R4: The stability count restarts whenever the synchronised level returns to match `key_clean_n`. Separate short disturbances therefore never add up to a transition, for either a press or a release.
- R5: With debouncing active, cycles without `ms_tick` neither advance the stability count nor change `key_clean_n`.
- R6: `dbnc_bypass` selects the filter: 0 = debouncing active (the state it should hold after reset), 1 = filter bypassed.
- R7: `press_pulse` is high for exactly one clock, in the cycle where `key_clean_n` first reads 0 after reading 1. A release produces no pulse.
- R8: `override_pulse` is high for exactly one clock, after the HOLD_TICKS-th `ms_tick` seen while `key_clean_n` was 0.
- R9: `override_pulse` fires at most once per continuous press. The hold count returns to zero whenever `key_clean_n` is 1, so a fresh press needs the full HOLD_TICKS again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_raw_n | input | 1 | Raw button pin, 0 = pressed |
| dbnc_bypass | input | 1 | 1 = skip debouncing, 0 = debounce |
| ms_tick | input | 1 | One-clock time-base pulse that paces both counters |
| key_clean_n | output | 1 | Debounced button level, 0 = pressed |
| press_pulse | output | 1 | One-clock pulse on each accepted press |
| override_pulse | output | 1 | One-clock pulse when a press outlasts the hold threshold |

## Verification
The assertions check properties that hold on every cycle:
- both pulses last a single clock;
- a press pulse coincides with a falling clean level;
- an override only follows a cycle with the button pressed;
- the clean level moves only to the synchronised value;
- with the filter on, the clean level cannot move without a tick;
- in bypass, the clean level tracks the synchroniser.

Only the bench scenarios can show the timing:
- how many ticks a transition needs;
- that short glitches are rejected on both edges;
- that the override fires once and then re-arms after a release;
- that reset forces the released state.

// File: rtl/btn_pkg.sv
package btn_pkg;

  // Counter width needed to hold the value n.
  function automatic int cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  // True when one more tick completes a span of 'limit' ticks.
  function automatic logic span_done(int unsigned seen, int unsigned limit);
    return (seen + 1) >= limit;
  endfunction

  // True when the hold count is exactly one tick short of the threshold.
  function automatic logic hold_hit(int unsigned seen, int unsigned limit);
    return (seen + 1) == limit;
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= RST_VAL;
        else        sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr <= {STAGES{RST_VAL}};
        else        sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned LIMIT = 16,
  parameter int          CW    = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  input  logic bypass,
  input  logic tick,
  output logic clean
);

  logic [CW-1:0] cnt;
  logic          differs;
  logic          expire;

  assign differs = (lvl_in != clean);
  assign expire  = btn_pkg::span_done(32'(cnt), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clean <= 1'b1;
      cnt   <= '0;
    end else if (bypass) begin
      clean <= lvl_in;
      cnt   <= '0;
    end else if (!differs) begin
      cnt   <= '0;
    end else if (tick) begin
      if (expire) begin
        clean <= lvl_in;
        cnt   <= '0;
      end else begin
        cnt   <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/btn_hold_timer.sv
module btn_hold_timer #(
  parameter int unsigned HOLD = 4001,
  parameter int          HW   = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clean_n,
  input  logic tick,
  output logic press,
  output logic override
);

  logic [HW-1:0] hcnt;
  logic          prev_n;
  logic          running;

  assign running = (32'(hcnt) < HOLD);
  assign press   = prev_n & ~clean_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n   <= 1'b1;
      hcnt     <= '0;
      override <= 1'b0;
    end else begin
      prev_n   <= clean_n;
      override <= 1'b0;
      if (clean_n) begin
        hcnt <= '0;
      end else if (tick && running) begin
        hcnt <= hcnt + HW'(1);
        if (btn_pkg::hold_hit(32'(hcnt), HOLD)) override <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int unsigned DBNC_TICKS  = 16,
  parameter int unsigned HOLD_TICKS  = 4001,
  parameter int          SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_raw_n,
  input  logic dbnc_bypass,
  input  logic ms_tick,
  output logic key_clean_n,
  output logic press_pulse,
  output logic override_pulse
);

  localparam int DCW = btn_pkg::cnt_width(DBNC_TICKS);
  localparam int HCW = btn_pkg::cnt_width(HOLD_TICKS);

  // Internal events brought out by name for the checker.
  logic sync_level;

  btn_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (key_raw_n),
    .q     (sync_level)
  );

  btn_debounce #(.LIMIT(DBNC_TICKS), .CW(DCW)) u_dbnc (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (sync_level),
    .bypass (dbnc_bypass),
    .tick   (ms_tick),
    .clean  (key_clean_n)
  );

  btn_hold_timer #(.HOLD(HOLD_TICKS), .HW(HCW)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clean_n  (key_clean_n),
    .tick     (ms_tick),
    .press    (press_pulse),
    .override (override_pulse)
  );

endmodule

// File: rtl/btn_conditioner_chk.sv
module btn_conditioner_chk (
  input logic clk,
  input logic rst_n,
  input logic bypass,
  input logic tick,
  input logic sync_level,
  input logic key_clean_n,
  input logic press_pulse,
  input logic override_pulse
);

  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |=> !press_pulse);                                   // R7

  AST_PRESS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    press_pulse |-> (!key_clean_n && $past(key_clean_n)));           // R7

  AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    override_pulse |=> !override_pulse);                             // R8

  AST_OVR_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    override_pulse |-> $past(!key_clean_n));                         // R9

  AST_MOVE_TO_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (key_clean_n != $past(key_clean_n)) |-> (key_clean_n == $past(sync_level))); // R3

  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !tick) |=> $stable(key_clean_n));                    // R5

  AST_BYPASS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (key_clean_n == $past(sync_level)));                  // R6

endmodule

bind btn_conditioner btn_conditioner_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bypass         (dbnc_bypass),
  .tick           (ms_tick),
  .sync_level     (sync_level),
  .key_clean_n    (key_clean_n),
  .press_pulse    (press_pulse),
  .override_pulse (override_pulse)
);

// File: tb/sim_btn_conditioner.sv
module sim_btn_conditioner;

  localparam int unsigned DB = 4;
  localparam int unsigned HD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_raw_n = 1'b1;
  logic dbnc_bypass = 1'b0;
  logic ms_tick = 1'b0;
  logic key_clean_n, press_pulse, override_pulse;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  btn_conditioner #(.DBNC_TICKS(DB), .HOLD_TICKS(HD)) u0 (
    .clk(clk), .rst_n(rst_n), .key_raw_n(key_raw_n), .dbnc_bypass(dbnc_bypass),
    .ms_tick(ms_tick), .key_clean_n(key_clean_n), .press_pulse(press_pulse),
    .override_pulse(override_pulse)
  );

  typedef struct packed {
    logic       raw;
    logic       byp;
    logic       tk;
    logic [7:0] n;
    logic       clean;
    logic [1:0] np;
    logic [1:0] no;
  } seg_t;

  // Each segment: pin, bypass, tick, cycles, expected clean level,
  // expected press pulses and expected override pulses during the segment.
  // DB=4, HD=10, tick every cycle when tk=1.
  localparam seg_t TBL [19] = '{
    '{1'b1, 1'b0, 1'b1, 8'd8,  1'b1, 2'd0, 2'd0},  //  0 R1 idle released
    '{1'b0, 1'b0, 1'b1, 8'd2,  1'b1, 2'd0, 2'd0},  //  1 R3 glitch low, seen 2 ticks
    '{1'b1, 1'b0, 1'b1, 8'd6,  1'b1, 2'd0, 2'd0},  //  2 R4 glitch rejected
    '{1'b0, 1'b0, 1'b1, 8'd12, 1'b0, 2'd1, 2'd0},  //  3 R3 press accepted at cycle 5
    '{1'b0, 1'b0, 1'b1, 8'd8,  1'b0, 2'd0, 2'd1},  //  4 R8 override at cycle 15
    '{1'b0, 1'b0, 1'b1, 8'd20, 1'b0, 2'd0, 2'd0},  //  5 R9 no second override
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b0, 2'd0, 2'd0},  //  6 R4 short release glitch
    '{1'b0, 1'b0, 1'b1, 8'd4,  1'b0, 2'd0, 2'd0},  //  7 R4 still pressed, no pulse
    '{1'b1, 1'b0, 1'b1, 8'd8,  1'b1, 2'd0, 2'd0},  //  8 R7 release gives no press
    '{1'b0, 1'b0, 1'b0, 8'd20, 1'b1, 2'd0, 2'd0},  //  9 R5 no ticks, no change
    '{1'b0, 1'b0, 1'b1, 8'd6,  1'b0, 2'd1, 2'd0},  // 10 R5 ticks resume, press at 3
    '{1'b1, 1'b0, 1'b1, 8'd8,  1'b1, 2'd0, 2'd0},  // 11 R9 release before threshold
    '{1'b0, 1'b0, 1'b1, 8'd14, 1'b0, 2'd1, 2'd0},  // 12 R9 timer restarted from zero
    '{1'b0, 1'b0, 1'b1, 8'd2,  1'b0, 2'd0, 2'd1},  // 13 R8 full hold reached
    '{1'b1, 1'b1, 1'b1, 8'd3,  1'b1, 2'd0, 2'd0},  // 14 R6 bypass release
    '{1'b0, 1'b1, 1'b1, 8'd3,  1'b0, 2'd1, 2'd0},  // 15 R2 bypass press, 3 edges
    '{1'b1, 1'b1, 1'b1, 8'd1,  1'b0, 2'd0, 2'd0},  // 16 R2 one edge not enough
    '{1'b1, 1'b1, 1'b1, 8'd2,  1'b1, 2'd0, 2'd0},  // 17 R2 third edge
    '{1'b1, 1'b0, 1'b1, 8'd4,  1'b1, 2'd0, 2'd0}   // 18 R6 back to debouncing
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int np;
    int no;
    repeat (3) @(negedge clk);
    check("R1 clean in reset", key_clean_n, 1);
    check("R1 press in reset", press_pulse, 0);
    check("R1 override in reset", override_pulse, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 clean after reset", key_clean_n, 1);
    check("R1 press after reset", press_pulse, 0);
    @(negedge clk);

    for (int s = 0; s < 19; s++) begin
      np = 0;
      no = 0;
      for (int j = 0; j < int'(TBL[s].n); j++) begin
        key_raw_n   = TBL[s].raw;
        dbnc_bypass = TBL[s].byp;
        ms_tick     = TBL[s].tk;
        @(posedge clk); #1;
        if (press_pulse)    np++;
        if (override_pulse) no++;
        @(negedge clk);
      end
      check($sformatf("R3/seg%0d clean level", s), key_clean_n, TBL[s].clean);
      check($sformatf("R7/seg%0d press count", s), np, TBL[s].np);
      check($sformatf("R8/seg%0d override count", s), no, TBL[s].no);
    end

    // R1: reset while the button is held forces the released state
    key_raw_n = 1'b0; dbnc_bypass = 1'b0; ms_tick = 1'b1;
    repeat (8) @(negedge clk);
    check("R1 pressed before reset", key_clean_n, 0);
    rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 clean forced by reset", key_clean_n, 1);
    check("R1 press quiet in reset", press_pulse, 0);
    check("R1 override quiet in reset", override_pulse, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 clean first cycle out of reset", key_clean_n, 1);
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule